// File: doc/BRIEF.md
# Dual-Mode VCO Band Calibration Controller

This block chooses the capacitor-bank setting of a PLL's oscillator before and during lock. Two calibration engines share one band code. The counting engine measures the divided feedback clock against the reference clock over a programmable window, compares the count with an expected value, and resolves the code one bit per window, starting at the most significant bit. The indicator engine acts on a pair of high/low flags that an external tuning-voltage comparator produces. It nudges the code one step per reference cycle until the comparator stays quiet.

The engine that drives the code follows the loop's lock status. While the lock detector reports lock, the indicator engine runs. While it reports unlock, the counting engine runs. The choice can change at any cycle without losing calibration progress. The divided-clock counter runs in its own clock domain, and its value crosses to the reference domain in Gray code. If lock is lost after calibration has finished, the block reopens the search from the code it holds.

Top module: `vcal_band_ctrl`

## Requirements
- R1: After reset the band code is 16 (only bit 4 set), the done flag is low, and the mode output is 0.
- R2: A cal_start pulse loads band code 16, clears done and begins calibration, all visible after the next ref_clk edge. A restart from the done state behaves the same way.
- R3: mode_ind equals lock_state delayed by one ref_clk edge. A value of 1 selects the indicator engine and 0 selects the counting engine.
- R4: In counting mode each window lasts win_len reference cycles plus one set-up cycle. A window decides the bit at the search pointer: the bit is set if the number of rising div_clk edges in the window is greater than exp_count, and cleared otherwise. The next lower bit is then set and every bit below it is cleared. The pointer starts at bit 4. Done rises when bit 0 has been decided, so a complete search takes five windows.
- R5: In indicator mode, on each ref_clk edge, ind_high alone adds 1 to the code and ind_low alone subtracts 1. When both flags are high, the code holds.
- R6: In indicator mode the code saturates at 31 when stepping up and at 0 when stepping down.
- R7: In indicator mode done rises on the QUIET_N-th consecutive edge (default 8) at which neither flag is high. Any flag resets this run of quiet edges.
- R8: A change of mode in the middle of a calibration keeps the counting engine's search pointer. After returning to counting mode, only the undecided bits cost a window each.
- R9: Once done is high, the code and done hold, and the indicator flags are ignored, until cal_start or a loss of lock.
- R10: A falling lock_state while done is high clears done on the next edge and sets bit 4 of the code while keeping its lower bits. The counting search then resumes from bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all control logic runs on it |
| div_clk | input | 1 | Divided oscillator feedback clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cal_start | input | 1 | Pulse that begins a calibration from midscale |
| lock_state | input | 1 | 1 while the lock detector reports lock, 0 while it reports unlock |
| ind_high | input | 1 | Comparator flag: tuning voltage high, raise the code |
| ind_low | input | 1 | Comparator flag: tuning voltage low, lower the code |
| win_len | input | WIN_W | Counting window length in reference cycles (at least 1) |
| exp_count | input | CNT_W | Expected divided-clock count for one window |
| band_code | output | CODE_W | Capacitor-bank code driven to the oscillator |
| cal_done | output | 1 | Calibration finished |
| mode_ind | output | 1 | 1 when the indicator engine is active, 0 for the counting engine |

## Verification
A corrupted search pointer or a stray window verdict shows up at the ports in two ways. The final band code lands on the wrong side of the frequency target, and done rises after the wrong number of windows, so a wrong count of windows is caught within about five windows of the start. A wrong quiet counter or a wrong saturation shows up within a few reference cycles, as an early or late done or a code that wraps. The bench models the oscillator so that its divided period grows with the code. It then compares both the final code and the time to done against values computed from the requirements.

// File: rtl/vcal_pkg.sv
`timescale 1ns/1ps
package vcal_pkg;
   typedef enum logic [1:0] {
      CAL_IDLE = 2'd0,
      CAL_RUN  = 2'd1,
      CAL_DONE = 2'd2
   } cal_state_e;
endpackage

// File: rtl/vcal_div_counter.sv
`timescale 1ns/1ps
module vcal_div_counter #(
   parameter int CNT_W = 16
) (
   input  logic             div_clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] gray_o
);
   logic [CNT_W-1:0] bin_q;
   logic [CNT_W-1:0] bin_nx;

   assign bin_nx = bin_q + CNT_W'(1);

   always_ff @(posedge div_clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         gray_o <= '0;
      end else begin
         bin_q  <= bin_nx;
         gray_o <= bin_nx ^ (bin_nx >> 1);
      end
   end
endmodule

// File: rtl/vcal_gray_sync.sv
`timescale 1ns/1ps
module vcal_gray_sync #(
   parameter int CNT_W  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] gray_i,
   output logic [CNT_W-1:0] bin_o
);
   for (genvar s = 0; s < STAGES; s++) begin : g_st
      logic [CNT_W-1:0] q;
      if (s == 0) begin : g_in
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= gray_i;
         end
      end else begin : g_ch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_st[s-1].q;
         end
      end
   end

   logic [CNT_W-1:0] gray_s;
   assign gray_s = g_st[STAGES-1].q;

   always_comb begin
      bin_o[CNT_W-1] = gray_s[CNT_W-1];
      for (int i = CNT_W - 2; i >= 0; i--) begin
         bin_o[i] = bin_o[i+1] ^ gray_s[i];
      end
   end
endmodule

// File: rtl/vcal_window.sv
`timescale 1ns/1ps
module vcal_window #(
   parameter int CNT_W = 16,
   parameter int WIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [WIN_W-1:0] win_len,
   input  logic [CNT_W-1:0] exp_count,
   input  logic [CNT_W-1:0] cnt_bin,
   output logic             verdict,
   output logic             fast
);
   logic             armed;
   logic [WIN_W-1:0] tick;
   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] seen;

   assign seen    = cnt_bin - base;
   assign fast    = seen > exp_count;
   assign verdict = run && armed && (tick == win_len - WIN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         tick  <= '0;
         base  <= '0;
      end else if (!run || verdict) begin
         armed <= 1'b0;
         tick  <= '0;
      end else if (!armed) begin
         armed <= 1'b1;
         tick  <= '0;
         base  <= cnt_bin;
      end else begin
         tick  <= tick + WIN_W'(1);
      end
   end
endmodule

// File: rtl/vcal_band_ctrl.sv
`timescale 1ns/1ps
module vcal_band_ctrl #(
   parameter int CODE_W      = 5,
   parameter int CNT_W       = 16,
   parameter int WIN_W       = 16,
   parameter int QUIET_N     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              ref_clk,
   input  logic              div_clk,
   input  logic              rst_n,
   input  logic              cal_start,
   input  logic              lock_state,
   input  logic              ind_high,
   input  logic              ind_low,
   input  logic [WIN_W-1:0]  win_len,
   input  logic [CNT_W-1:0]  exp_count,
   output logic [CODE_W-1:0] band_code,
   output logic              cal_done,
   output logic              mode_ind
);
   import vcal_pkg::*;

   localparam int PTR_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
   localparam int Q_W   = $clog2(QUIET_N + 1);
   localparam logic [PTR_W-1:0]  PTR_MSB  = PTR_W'(CODE_W - 1);
   localparam logic [CODE_W-1:0] MIDSCALE = CODE_W'(1) << (CODE_W - 1);
   localparam logic [CODE_W-1:0] CODE_MAX = '1;

   if (CODE_W < 2) begin : g_bad_code
      $error("vcal_band_ctrl: CODE_W must be at least 2");
   end
   if (QUIET_N < 1) begin : g_bad_quiet
      $error("vcal_band_ctrl: QUIET_N must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("vcal_band_ctrl: SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 4) begin : g_bad_cnt
      $error("vcal_band_ctrl: CNT_W must be at least 4");
   end

   cal_state_e        state;
   logic [CODE_W-1:0] code;
   logic [PTR_W-1:0]  ptr;
   logic [Q_W-1:0]    quiet;
   logic              mode_q;

   logic [CNT_W-1:0]  div_gray;
   logic [CNT_W-1:0]  div_bin;
   logic              win_run;
   logic              verdict;
   logic              fast;
   logic              lock_fall;
   logic              calibrating;
   logic [CODE_W-1:0] sar_next;

   vcal_div_counter #(.CNT_W(CNT_W)) u_divcnt (
      .div_clk (div_clk),
      .rst_n   (rst_n),
      .gray_o  (div_gray)
   );

   vcal_gray_sync #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (ref_clk),
      .rst_n  (rst_n),
      .gray_i (div_gray),
      .bin_o  (div_bin)
   );

   assign calibrating = (state == CAL_RUN);
   assign win_run     = calibrating && !mode_q && !cal_start;
   assign lock_fall   = mode_q && !lock_state;

   vcal_window #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_win (
      .clk       (ref_clk),
      .rst_n     (rst_n),
      .run       (win_run),
      .win_len   (win_len),
      .exp_count (exp_count),
      .cnt_bin   (div_bin),
      .verdict   (verdict),
      .fast      (fast)
   );

   always_comb begin
      sar_next = code;
      for (int b = 0; b < CODE_W; b++) begin
         if (b == int'(ptr))          sar_next[b] = fast;
         else if (b == int'(ptr) - 1) sar_next[b] = 1'b1;
         else if (b < int'(ptr) - 1)  sar_next[b] = 1'b0;
      end
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= CAL_IDLE;
         code   <= MIDSCALE;
         ptr    <= PTR_MSB;
         quiet  <= '0;
         mode_q <= 1'b0;
      end else begin
         mode_q <= lock_state;
         if (cal_start) begin
            state <= CAL_RUN;
            code  <= MIDSCALE;
            ptr   <= PTR_MSB;
            quiet <= '0;
         end else if (state == CAL_DONE && lock_fall) begin
            state <= CAL_RUN;
            code  <= code | MIDSCALE;
            ptr   <= PTR_MSB;
            quiet <= '0;
         end else if (state == CAL_RUN) begin
            if (!mode_q) begin
               quiet <= '0;
               if (verdict) begin
                  code <= sar_next;
                  if (ptr == '0) state <= CAL_DONE;
                  else           ptr   <= ptr - PTR_W'(1);
               end
            end else if (ind_high && !ind_low) begin
               quiet <= '0;
               if (code != CODE_MAX) code <= code + CODE_W'(1);
            end else if (ind_low && !ind_high) begin
               quiet <= '0;
               if (code != '0) code <= code - CODE_W'(1);
            end else if (ind_high && ind_low) begin
               quiet <= '0;
            end else if (quiet == Q_W'(QUIET_N - 1)) begin
               quiet <= '0;
               state <= CAL_DONE;
            end else begin
               quiet <= quiet + Q_W'(1);
            end
         end
      end
   end

   assign band_code = code;
   assign cal_done  = (state == CAL_DONE);
   assign mode_ind  = mode_q;
endmodule

// File: rtl/vcal_band_ctrl_checks.sv
`timescale 1ns/1ps
module vcal_band_ctrl_checks #(
   parameter int CODE_W = 5
) (
   input logic              ref_clk,
   input logic              rst_n,
   input logic              cal_start,
   input logic              lock_state,
   input logic              ind_high,
   input logic              ind_low,
   input logic [CODE_W-1:0] band_code,
   input logic              cal_done,
   input logic              mode_ind,
   input logic              in_cal
);
   localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
   localparam logic [CODE_W-1:0] TOP = '1;

   logic up_req;
   logic dn_req;
   assign up_req = in_cal && mode_ind && ind_high && !ind_low && !cal_start;
   assign dn_req = in_cal && mode_ind && ind_low && !ind_high && !cal_start;

   assert_start_mid_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
      cal_start |=> (band_code == MID) && !cal_done);

   assert_mode_follow_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      1'b1 |=> (mode_ind == $past(lock_state)));

   assert_step_up_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (up_req && band_code != TOP) |=> band_code == $past(band_code) + CODE_W'(1));

   assert_step_down_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (dn_req && band_code != '0) |=> band_code == $past(band_code) - CODE_W'(1));

   assert_sat_top_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (up_req && band_code == TOP) |=> band_code == TOP);

   assert_sat_bottom_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (dn_req && band_code == '0) |=> band_code == '0);

   assert_hold_done_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (cal_done && !cal_start && !(mode_ind && !lock_state)) |=> $stable(band_code) && cal_done);

   assert_relock_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (cal_done && mode_ind && !lock_state && !cal_start) |=> !cal_done && band_code[CODE_W-1]);
endmodule

bind vcal_band_ctrl vcal_band_ctrl_checks #(.CODE_W(CODE_W)) u_checks (
   .ref_clk    (ref_clk),
   .rst_n      (rst_n),
   .cal_start  (cal_start),
   .lock_state (lock_state),
   .ind_high   (ind_high),
   .ind_low    (ind_low),
   .band_code  (band_code),
   .cal_done   (cal_done),
   .mode_ind   (mode_ind),
   .in_cal     (calibrating)
);

// File: tb/vcal_band_ctrl_test.sv
`timescale 1ns/1ps
module vcal_band_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int WIN        = 1000;
   localparam int EXPC       = 122;
   localparam int QN         = 8;

   logic        ref_clk = 1'b0;
   logic        div_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cal_start = 1'b0;
   logic        lock_state = 1'b0;
   logic        ind_high = 1'b0;
   logic        ind_low = 1'b0;
   logic [15:0] win_len = 16'(WIN);
   logic [15:0] exp_count = 16'(EXPC);
   logic [4:0]  band_code;
   logic        cal_done;
   logic        mode_ind;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   real half_ns;

   vcal_band_ctrl uut (
      .ref_clk(ref_clk), .div_clk(div_clk), .rst_n(rst_n), .cal_start(cal_start),
      .lock_state(lock_state), .ind_high(ind_high), .ind_low(ind_low),
      .win_len(win_len), .exp_count(exp_count),
      .band_code(band_code), .cal_done(cal_done), .mode_ind(mode_ind)
   );

   always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

   // Oscillator model: divided period grows by 4 ns per code step.
   always begin
      half_ns = (40.0 + 4.0 * real'(band_code)) / 2.0;
      #(half_ns) div_clk = ~div_clk;
   end

   function automatic bit is_fast(int c);
      return (10.0 * real'(WIN) / (40.0 + 4.0 * real'(c))) > real'(EXPC);
   endfunction

   function automatic int sar_model(int start);
      int c = start;
      for (int k = 4; k >= 0; k--) begin
         bit f = is_fast(c);
         c = f ? (c | (1 << k)) : (c & ~(1 << k));
         if (k > 0) begin
            c = c | (1 << (k - 1));
            c = c & ~((1 << (k - 1)) - 1);
         end
      end
      return c;
   endfunction

   task automatic check(string req, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge ref_clk);
   endtask

   task automatic pulse_start();
      cal_start = 1'b1;
      tick(1);
      cal_start = 1'b0;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (!cal_done && n < 20000) begin
         tick(1);
         n++;
      end
   endtask

   task automatic drive(bit h, bit l, int n);
      ind_high = h;
      ind_low  = l;
      tick(n);
      ind_high = 1'b0;
      ind_low  = 1'b0;
   endtask

   task automatic test_reset();
      tick(3);
      check("R1 code", int'(band_code), 16);
      check("R1 done", int'(cal_done), 0);
      check("R1 mode", int'(mode_ind), 0);
      rst_n = 1'b1;
      tick(2);
   endtask

   task automatic test_counter_search();
      int n;
      lock_state = 1'b0;
      tick(2);
      pulse_start();
      check("R2 midscale", int'(band_code), 16);
      check("R2 done clear", int'(cal_done), 0);
      wait_done(n);
      check("R4 done reached", int'(cal_done), 1);
      check("R4 not before five windows", int'(n > 4 * WIN), 1);
      check("R4 within five windows", int'(n <= 5 * (WIN + 1) + 10), 1);
      check("R4 final code", int'(band_code), sar_model(16));
   endtask

   task automatic test_indicator();
      lock_state = 1'b1;
      tick(1);
      check("R3 mode indicator", int'(mode_ind), 1);
      pulse_start();
      check("R2 restart from done", int'(cal_done), 0);
      drive(1, 0, 3);
      check("R5 step up", int'(band_code), 19);
      drive(0, 1, 5);
      check("R5 step down", int'(band_code), 14);
      drive(1, 1, 2);
      check("R5 both hold", int'(band_code), 14);
      drive(1, 0, 20);
      check("R6 saturate high", int'(band_code), 31);
      drive(0, 1, 40);
      check("R6 saturate low", int'(band_code), 0);
      drive(1, 0, 12);
      check("R5 up from zero", int'(band_code), 12);
      tick(QN - 1);
      check("R7 not done early", int'(cal_done), 0);
      tick(1);
      check("R7 done after quiet run", int'(cal_done), 1);
      drive(1, 0, 5);
      check("R9 code held", int'(band_code), 12);
      check("R9 done held", int'(cal_done), 1);
   endtask

   task automatic test_relock();
      int n;
      lock_state = 1'b0;
      tick(1);
      check("R10 done cleared", int'(cal_done), 0);
      check("R10 msb set", int'(band_code), 28);
      tick(1);
      check("R3 mode counter", int'(mode_ind), 0);
      wait_done(n);
      check("R10 resumed search", int'(band_code), sar_model(28));
   endtask

   task automatic test_switch();
      int n;
      int c0;
      lock_state = 1'b0;
      tick(2);
      pulse_start();
      check("R2 midscale again", int'(band_code), 16);
      tick(2 * WIN + 10);
      c0 = int'(band_code);
      lock_state = 1'b1;
      tick(1);
      for (int i = 0; i < 10; i++) begin
         ind_high = (i % 2 == 0);
         ind_low  = (i % 2 == 1);
         tick(1);
      end
      ind_high = 1'b0;
      ind_low  = 1'b0;
      lock_state = 1'b0;
      tick(1);
      check("R8 no done in switch", int'(cal_done), 0);
      check("R8 code kept", int'(band_code), c0);
      wait_done(n);
      check("R8 remaining windows only", int'(n <= 3 * (WIN + 1) + 10), 1);
      check("R8 more than two windows", int'(n > 2 * WIN), 1);
      check("R8 final code", int'(band_code), sar_model(16));
   endtask

   initial begin
      test_reset();
      test_counter_search();
      test_indicator();
      test_relock();
      test_switch();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule